// File: doc/BRIEF.md
# LFSR Sequence Self-Test Checker

This block judges a buffer of 64-bit words that a random-number source produced while running in a known, deterministic health-check mode. On a start request it latches a seed and a feedback mask, and then walks the buffer one word per clock. The first word (index 0) is skipped. Every other word that equals the current expected value adds one to a running match total.

After each full pass over the buffer, the block compares the total with a match goal. If the goal is met, the check ends with pass. If it is not met, the expected value moves one step along a left-shifting Galois LFSR and a new pass begins. The total is not cleared between passes. If the permitted number of passes runs out before the goal is met, the check ends with fail.

The buffer sits outside the block. The block drives a word index and reads the addressed word back in the same cycle, through an asynchronous read port.

Top module: `lfsr_selftest_chk`

## Requirements
- R1: One LFSR step samples bit 63 of the value, shifts the value left by one with a 0 entering bit 0, and XORs the latched mask into the result only when the sampled bit was 1.
- R2: Word index 0 is never compared. Each pass presents indices 1 to WORDS-1 on `rd_addr`, one per clock, in increasing order.
- R3: Every scanned word equal to the expected value adds one to the total, so duplicates within a pass each count.
- R4: The match total carries over from pass to pass and is cleared only when a start is accepted.
- R5: The goal is evaluated at the end of each full pass. The check passes when the total is at least GOAL.
- R6: When LOOP_MAX passes have completed and the goal has not been met, the check fails. A goal first met on pass LOOP_MAX still passes.
- R7: The first pass uses the latched seed. After each pass that does not end the check, the expected value advances by exactly one step.
- R8: `done` is a one-cycle pulse in the cycle after the last compare of the final pass. Exactly one of `pass` or `fail` rises with it, and that flag stays high until the next accepted start.
- R9: A start request made while a check is running is ignored, together with any change to `seed` or `poly_mask`.
- R10: After reset, `done`, `pass` and `fail` are low and the block is idle, ready for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check; accepted only when idle |
| seed | input | 64 | Initial expected value, latched on start |
| poly_mask | input | 64 | LFSR feedback mask, latched on start |
| rd_addr | output | IW | Buffer word index being compared |
| rd_data | input | 64 | Buffer word at `rd_addr` (same-cycle read) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Goal reached; held until next start |
| fail | output | 1 | Pass limit reached without goal; held until next start |

## Verification
Two events can fall on the same final compare cycle of a pass: the last word of the pass can be the match that reaches the goal, and that same pass can also be the last one allowed. The bench provokes this by placing the expected values for steps 4 and 5 so that the goal is completed on pass LOOP_MAX. It expects pass and not fail. It also places a match on the final index of a pass in an earlier case. A stray start with a matching seed is injected mid-run to confirm that the check in progress is neither restarted nor altered.

// File: rtl/lfsr_chk_pkg.sv
package lfsr_chk_pkg;
  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {ST_IDLE, ST_SCAN} chk_state_e;

  // one Galois step: shift left, fold mask in when the old MSB was set
  function automatic word_t lfsr_next(input word_t val, input word_t mask);
    return {val[WORD_W-2:0], 1'b0} ^ (mask & {WORD_W{val[WORD_W-1]}});
  endfunction
endpackage

// File: rtl/lfsr_chk_expect.sv
module lfsr_chk_expect
  import lfsr_chk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  advance,
  input  word_t seed,
  input  word_t mask_in,
  output word_t exp_val
);
  word_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_val <= '0;
      mask_q  <= '0;
    end else if (load) begin
      exp_val <= seed;
      mask_q  <= mask_in;
    end else if (advance) begin
      exp_val <= lfsr_next(exp_val, mask_q);
    end
  end
endmodule

// File: rtl/lfsr_chk_scan.sv
module lfsr_chk_scan #(
  parameter int WORDS = 8,
  localparam int IW = (WORDS > 2) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          scanning,
  output logic [IW-1:0] idx,
  output logic          last
);
  localparam logic [IW-1:0] FIRST = IW'(1);
  localparam logic [IW-1:0] FINAL = IW'(WORDS - 1);

  assign last = (idx == FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= FIRST;
    else if (load)       idx <= FIRST;
    else if (scanning)   idx <= last ? FIRST : idx + IW'(1);
  end
endmodule

// File: rtl/lfsr_chk_tally.sv
module lfsr_chk_tally #(
  parameter int CW  = 8,
  parameter int ITW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           scanning,
  input  logic           hit,
  input  logic           iter_end,
  output logic [CW-1:0]  total,
  output logic [CW-1:0]  total_sum,
  output logic [ITW-1:0] iter_after
);
  logic [ITW-1:0] iter_q;

  assign total_sum  = total + CW'(hit);
  assign iter_after = iter_q + ITW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total  <= '0;
      iter_q <= '0;
    end else if (clear) begin
      total  <= '0;
      iter_q <= '0;
    end else if (scanning) begin
      total <= total_sum;
      if (iter_end) iter_q <= iter_after;
    end
  end
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk
  import lfsr_chk_pkg::*;
#(
  parameter int WORDS    = 8,
  parameter int GOAL     = 2,
  parameter int LOOP_MAX = 16,
  localparam int IW  = (WORDS > 2) ? $clog2(WORDS) : 1,
  localparam int CW  = $clog2(LOOP_MAX * WORDS + GOAL + 1) + 1,
  localparam int ITW = $clog2(LOOP_MAX + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [63:0]   seed,
  input  logic [63:0]   poly_mask,
  output logic [IW-1:0] rd_addr,
  input  logic [63:0]   rd_data,
  output logic          done,
  output logic          pass,
  output logic          fail
);
  localparam logic [CW-1:0]  GOAL_C  = CW'(GOAL);
  localparam logic [ITW-1:0] LIMIT_C = ITW'(LOOP_MAX);

  chk_state_e     state;
  word_t          exp_val;
  logic           scanning, start_acc, hit, last, iter_end;
  logic           goal_met, limit_hit, finish, advance;
  logic [CW-1:0]  total, total_sum;
  logic [ITW-1:0] iter_after;

  // named events for the checker
  assign scanning  = (state == ST_SCAN);
  assign start_acc = start && (state == ST_IDLE);
  assign hit       = scanning && (rd_data == exp_val);
  assign iter_end  = scanning && last;
  assign goal_met  = iter_end && (total_sum >= GOAL_C);
  assign limit_hit = iter_end && !goal_met && (iter_after >= LIMIT_C);
  assign finish    = goal_met || limit_hit;
  assign advance   = iter_end && !finish;

  lfsr_chk_expect u_expect (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .advance(advance),
    .seed(seed), .mask_in(poly_mask), .exp_val(exp_val)
  );

  lfsr_chk_scan #(.WORDS(WORDS)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .scanning(scanning),
    .idx(rd_addr), .last(last)
  );

  lfsr_chk_tally #(.CW(CW), .ITW(ITW)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .scanning(scanning),
    .hit(hit), .iter_end(iter_end), .total(total), .total_sum(total_sum),
    .iter_after(iter_after)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= finish;
      if (start_acc) begin
        state <= ST_SCAN;
        pass  <= 1'b0;
        fail  <= 1'b0;
      end else if (finish) begin
        state <= ST_IDLE;
        pass  <= goal_met;
        fail  <= limit_hit;
      end
    end
  end
endmodule

// File: rtl/lfsr_selftest_chk_sva.sv
module lfsr_selftest_chk_sva #(
  parameter int IW = 3,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [IW-1:0] rd_addr,
  input logic          scanning,
  input logic          hit,
  input logic          advance,
  input logic [63:0]   exp_val,
  input logic [CW-1:0] total
);
  assert_skip_word0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> rd_addr != '0);

  assert_hit_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && hit) |=> total == $past(total) + CW'(1));

  assert_total_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && !hit) |=> $stable(total));

  assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_hold_expect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && !advance) |=> $stable(exp_val));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && start) |=> total >= $past(total));
endmodule

bind lfsr_selftest_chk lfsr_selftest_chk_sva #(.IW(IW), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
  .fail(fail), .rd_addr(rd_addr), .scanning(scanning), .hit(hit),
  .advance(advance), .exp_val(exp_val), .total(total)
);

// File: tb/lfsr_selftest_chk_tb_top.sv
module lfsr_selftest_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 8;
  localparam int GOAL = 2;
  localparam int LOOP_MAX = 6;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] seed = '0, poly_mask = '0;
  logic [IW-1:0] rd_addr;
  logic [63:0] rd_data;
  logic done, pass, fail;
  logic [63:0] mem [WORDS];

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = mem[rd_addr];

  lfsr_selftest_chk #(.WORDS(WORDS), .GOAL(GOAL), .LOOP_MAX(LOOP_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .poly_mask(poly_mask),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .pass(pass), .fail(fail)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [63:0] ref_step(input logic [63:0] v, input logic [63:0] m);
    logic [63:0] r;
    r = v << 1;
    if (v[63] == 1'b1) r = r ^ m;
    return r;
  endfunction

  function automatic logic [63:0] ref_walk(input logic [63:0] v, input logic [63:0] m, input int k);
    logic [63:0] r = v;
    for (int i = 0; i < k; i++) r = ref_step(r, m);
    return r;
  endfunction

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_pass = 0, m_fail = 0;
  int m_idx = 1, m_total = 0, m_pass_no = 0;
  logic [63:0] m_exp = '0, m_mask = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
      m_idx = 1; m_total = 0; m_pass_no = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_pass = 0; m_fail = 0; m_idx = 1;
          m_total = 0; m_pass_no = 0; m_exp = seed; m_mask = poly_mask;
        end
      end else begin
        if (mem[m_idx] == m_exp) m_total++;
        if (m_idx == WORDS - 1) begin
          m_idx = 1;
          m_pass_no++;
          if (m_total >= GOAL) begin
            m_busy = 0; m_done = 1; m_pass = 1;
          end else if (m_pass_no >= LOOP_MAX) begin
            m_busy = 0; m_done = 1; m_fail = 1;
          end else begin
            m_exp = ref_step(m_exp, m_mask);
          end
        end else begin
          m_idx++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(done == m_done, "R8 done", done, m_done);
      check(pass == m_pass, "R5 pass", pass, m_pass);
      check(fail == m_fail, "R6 fail", fail, m_fail);
      if (m_busy) check(rd_addr == IW'(m_idx), "R2 rd_addr", rd_addr, m_idx);
    end
  end

  task automatic fill_junk();
    for (int i = 0; i < WORDS; i++) mem[i] = 64'h5A5A_0000_C3C3_0000 + 64'(i * 7919);
  endtask

  task automatic run(input logic [63:0] s, input logic [63:0] m, input int n_exp,
                     input bit exp_pass, input int inject, input string tag);
    int cnt = 0;
    seed = s; poly_mask = m; start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    while (!done && cnt < 1000) begin
      if (cnt == inject) begin start = 1; seed = mem[3]; end
      else start = 0;
      @(posedge clk); cnt++; @(negedge clk);
    end
    start = 0;
    check(cnt == n_exp * (WORDS - 1), {tag, " latency"}, cnt, n_exp * (WORDS - 1));
    check(pass == exp_pass && fail == !exp_pass, {tag, " verdict"}, {pass, fail}, {exp_pass, !exp_pass});
    repeat (3) @(negedge clk);
    check(pass == exp_pass && !done, {tag, " R8 held"}, pass, exp_pass);
  endtask

  initial begin
    logic [63:0] s, m;
    fill_junk();
    repeat (3) @(negedge clk);
    check(!done && !pass && !fail, "R10 reset", {done, pass, fail}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !pass && !fail, "R10 idle", {done, pass, fail}, 0);

    // R1 R2 R7: MSB-set seed; word 0 holds seed but is skipped
    s = 64'h8123_4567_89AB_CDEF; m = 64'h2639_D18E_1B0E_A8A3;
    fill_junk(); mem[0] = s; mem[3] = s; mem[7] = ref_step(s, m);
    check(ref_step(s, m) == ({s[62:0], 1'b0} ^ m), "R1 step", ref_step(s, m), {s[62:0], 1'b0} ^ m);
    run(s, m, 2, 1, -1, "R2 R7 skip0");

    // R3: duplicates in one pass
    s = 64'h0000_1111_2222_3333;
    fill_junk(); mem[2] = s; mem[5] = s;
    run(s, m, 1, 1, -1, "R3 dup");

    // R4: matches spread over passes
    fill_junk(); mem[1] = ref_walk(s, m, 1); mem[6] = ref_walk(s, m, 4);
    run(s, m, 5, 1, -1, "R4 accum");

    // R6: no matches
    fill_junk();
    run(s, m, LOOP_MAX, 0, -1, "R6 limit");

    // R5 R6: goal completed on the last allowed pass, on the final index
    s = 64'hF000_0000_0000_0001;
    fill_junk(); mem[4] = ref_walk(s, m, 4); mem[7] = ref_walk(s, m, 5);
    run(s, m, LOOP_MAX, 1, -1, "R5 edge");

    // R9: stray start with seed = mem[3] mid-run must not restart
    fill_junk();
    run(s, 64'hFFFF_0000_FFFF_0000, LOOP_MAX, 0, 9, "R9 ignore");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule